// File: doc/BRIEF.md
# Next Program Counter and Branch Resolution Unit

This block works out where a 32-bit processor fetches next. It receives the current program counter, the instruction word at that address, and the values of the two source registers that the instruction names. It recognises four kinds of control transfer: branch-if-equal, branch-if-not-equal, an unconditional jump within the current 256 MiB region, and a jump through a register. It decides whether the transfer is taken and returns the next fetch address. Any other instruction, and any branch that is not taken, moves on to the following word. A signed less-than flag on the two register values is also provided, so that a compare-then-branch sequence can be built around the unit.

The address and taken outputs are purely combinational. A parameter selects whether the block also keeps a program counter register. When that register is present, it loads the reset vector and then takes the computed next address on every clock. When it is absent, the register output simply passes the current PC through. All pins are plain control and data signals with no handshake. A result is valid in the same cycle as its inputs, so there is no back-pressure to manage.

Top module: `npc_unit`

## Requirements
- R1: An instruction whose opcode (bits 31:26) is not 0, 2, 4 or 5 gives next_pc = cur_pc + 4 and taken = 0.
- R2: Opcode 4 (branch-if-equal), with rs_val equal to rt_val, gives taken = 1 and next_pc = cur_pc + 4 + 4 × offset, where the offset is bits 15:0. With unequal values it gives taken = 0 and next_pc = cur_pc + 4.
- R3: Opcode 5 (branch-if-not-equal) is taken, with the same target rule as R2, exactly when rs_val differs from rt_val. Otherwise it gives cur_pc + 4.
- R4: The 16-bit branch offset is a signed two's-complement word count, so 16'hFFFD moves three words back from cur_pc + 4. All address arithmetic wraps modulo 2^32.
- R5: Opcode 2 (jump) is always taken. next_pc keeps bits 31:28 of cur_pc, and its bits 27:0 are the 26-bit field in bits 25:0 times four.
- R6: Opcode 0 with function code 8 (bits 5:0) is a register jump: taken = 1 and next_pc = rs_val.
- R7: Opcode 0 with any other function code behaves as in R1.
- R8: less_than is 1 exactly when rs_val is less than rt_val as signed 32-bit values, whatever the instruction.
- R9: With REG_PC = 1, a clock edge while rst is high loads pc_q with RESET_VEC (default 32'h0000_0000).
- R10: With REG_PC = 1, a clock edge while rst is low loads pc_q with the next_pc value that was present before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional PC register |
| rst | input | 1 | Synchronous active-high reset of pc_q |
| cur_pc | input | 32 | Address of the instruction being resolved |
| instr | input | 32 | Instruction word |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| next_pc | output | 32 | Next fetch address |
| taken | output | 1 | High when a control transfer redirects the fetch |
| less_than | output | 1 | Signed rs_val < rt_val |
| pc_q | output | 32 | Registered program counter, or cur_pc when REG_PC = 0 |

## Verification
next_pc, taken and less_than depend only on the current inputs. They are due in the same cycle the inputs change. The bench drives new inputs just after a rising edge and compares these three outputs at the following falling edge. pc_q is due one rising edge after the next_pc value it captures. So the bench reference model registers its own expected next address at each rising edge and compares pc_q at every falling edge, including across reset.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam logic [5:0] OP_SPECIAL = 6'd0;
  localparam logic [5:0] OP_JUMP    = 6'd2;
  localparam logic [5:0] OP_BR_EQ   = 6'd4;
  localparam logic [5:0] OP_BR_NE   = 6'd5;
  localparam logic [5:0] FN_REGJMP  = 6'd8;

  typedef enum logic [1:0] {
    XF_SEQ    = 2'd0,
    XF_PCREL  = 2'd1,
    XF_REGION = 2'd2,
    XF_REG    = 2'd3
  } xfer_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [31:0] instr,
  output xfer_e       kind,
  output logic        cond_br,
  output logic        br_on_eq
);
  logic [5:0] opc;
  logic [5:0] fnc;

  assign opc = instr[31:26];
  assign fnc = instr[5:0];

  always_comb begin
    kind     = XF_SEQ;
    cond_br  = 1'b0;
    br_on_eq = 1'b0;
    unique case (opc)
      OP_JUMP:    kind = XF_REGION;
      OP_BR_EQ: begin
        kind     = XF_PCREL;
        cond_br  = 1'b1;
        br_on_eq = 1'b1;
      end
      OP_BR_NE: begin
        kind    = XF_PCREL;
        cond_br = 1'b1;
      end
      OP_SPECIAL: begin
        if (fnc == FN_REGJMP) kind = XF_REG;
      end
      default: kind = XF_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_compare.sv
module npc_compare #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         equal,
  output logic         lt_signed
);
  logic [W:0] diff;
  logic       sgn_a, sgn_b;

  assign sgn_a = a[W-1];
  assign sgn_b = b[W-1];
  assign diff  = {1'b0, a} - {1'b0, b};
  assign equal = (diff[W-1:0] == '0);

  always_comb begin
    if (sgn_a != sgn_b) lt_signed = sgn_a;
    else                lt_signed = diff[W];
  end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int W     = 32,
  parameter int OFF_W = 16,
  parameter int JT_W  = 26
) (
  input  logic [W-1:0]  pc,
  input  logic [31:0]   instr,
  output logic [W-1:0]  seq_addr,
  output logic [W-1:0]  rel_addr,
  output logic [W-1:0]  region_addr
);
  localparam int REGION_W = W - JT_W - 2;
  localparam int EXT_W    = W - OFF_W - 2;

  logic [OFF_W-1:0] off;
  logic [W-1:0]     off_scaled;

  assign off        = instr[OFF_W-1:0];
  assign off_scaled = {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
  assign seq_addr   = pc + W'(4);
  assign rel_addr   = seq_addr + off_scaled;

  generate
    if (REGION_W > 0) begin : g_region
      assign region_addr = {pc[W-1 -: REGION_W], instr[JT_W-1:0], 2'b00};
    end else begin : g_flat
      assign region_addr = W'({instr[JT_W-1:0], 2'b00});
    end
  endgenerate
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int          W         = 32,
  parameter bit          REG_PC    = 1'b1,
  parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [31:0]  cur_pc,
  input  logic [31:0]  instr,
  input  logic [31:0]  rs_val,
  input  logic [31:0]  rt_val,
  output logic [31:0]  next_pc,
  output logic         taken,
  output logic         less_than,
  output logic [31:0]  pc_q
);
  xfer_e       kind;
  logic        cond_br, br_on_eq;
  logic        eq, lt;
  logic [31:0] seq_a, rel_a, reg_a;
  logic        cond_ok;

  npc_decode u_dec (
    .instr    (instr),
    .kind     (kind),
    .cond_br  (cond_br),
    .br_on_eq (br_on_eq)
  );

  npc_compare #(.W(W)) u_cmp (
    .a         (rs_val),
    .b         (rt_val),
    .equal     (eq),
    .lt_signed (lt)
  );

  npc_target #(.W(W)) u_tgt (
    .pc          (cur_pc),
    .instr       (instr),
    .seq_addr    (seq_a),
    .rel_addr    (rel_a),
    .region_addr (reg_a)
  );

  assign cond_ok   = br_on_eq ? eq : !eq;
  assign less_than = lt;

  always_comb begin
    taken   = 1'b0;
    next_pc = seq_a;
    case (kind)
      XF_PCREL: begin
        if (cond_br && cond_ok) begin
          taken   = 1'b1;
          next_pc = rel_a;
        end
      end
      XF_REGION: begin
        taken   = 1'b1;
        next_pc = reg_a;
      end
      XF_REG: begin
        taken   = 1'b1;
        next_pc = rs_val;
      end
      default: ;
    endcase
  end

  generate
    if (REG_PC) begin : g_pcreg
      logic [31:0] pc_r;
      always_ff @(posedge clk) begin
        if (rst) pc_r <= RESET_VEC;
        else     pc_r <= next_pc;
      end
      assign pc_q = pc_r;

      a_r9_reset_vector: assert property (@(posedge clk)
        rst |=> pc_q == RESET_VEC);
      a_r10_pc_follows: assert property (@(posedge clk) disable iff (rst)
        !rst |=> pc_q == $past(next_pc));
    end else begin : g_pcpass
      assign pc_q = cur_pc;
    end
  endgenerate

  a_r1_untaken_sequential: assert property (@(posedge clk) disable iff (rst)
    !taken |-> next_pc == cur_pc + 32'd4);
  a_r2_eq_untaken: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == OP_BR_EQ && rs_val != rt_val) |-> !taken);
  a_r3_ne_untaken: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == OP_BR_NE && rs_val == rt_val) |-> !taken);
  a_r5_region_kept: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == OP_JUMP) |-> (taken && next_pc[31:28] == cur_pc[31:28]
                                   && next_pc[1:0] == 2'b00));
  a_r6_reg_jump: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == OP_SPECIAL && instr[5:0] == FN_REGJMP) |-> (taken && next_pc == rs_val));
  a_r8_lt_irreflexive: assert property (@(posedge clk) disable iff (rst)
    (rs_val == rt_val) |-> !less_than);
endmodule

// File: tb/sim_npc_unit.sv
`timescale 1ns/1ps
module sim_npc_unit;
  localparam logic [31:0] RV = 32'h0000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cur_pc = '0, instr = '0, rs_val = '0, rt_val = '0;
  logic [31:0] next_pc, pc_q;
  logic        taken, less_than;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_pcq = '0;
  bit          pcq_known = 1'b0;

  always #2.5 clk = ~clk;

  npc_unit #(.REG_PC(1'b1), .RESET_VEC(RV)) u0 (
    .clk(clk), .rst(rst), .cur_pc(cur_pc), .instr(instr),
    .rs_val(rs_val), .rt_val(rt_val), .next_pc(next_pc),
    .taken(taken), .less_than(less_than), .pc_q(pc_q)
  );

  function automatic logic [32:0] model(input logic [31:0] ins, input logic [31:0] pc,
                                        input logic [31:0] a, input logic [31:0] b);
    int unsigned op, fn;
    longint      off;
    logic [31:0] seq;
    op  = ins[31:26];
    fn  = ins[5:0];
    seq = pc + 32'd4;
    off = longint'($signed(ins[15:0]));
    if (op == 2) return {1'b1, (pc & 32'hF000_0000) + ins[25:0] * 32'd4};
    if (op == 4 && a == b) return {1'b1, 32'(longint'(seq) + off * 4)};
    if (op == 5 && a != b) return {1'b1, 32'(longint'(seq) + off * 4)};
    if (op == 0 && fn == 8) return {1'b1, a};
    return {1'b0, seq};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      exp_pcq   <= RV;
      pcq_known <= 1'b1;
    end else begin
      exp_pcq <= model(instr, cur_pc, rs_val, rt_val);
    end
  end

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [31:0] ins, input logic [31:0] pc,
                       input logic [31:0] a, input logic [31:0] b);
    logic [32:0] m;
    @(posedge clk);
    #1;
    instr = ins; cur_pc = pc; rs_val = a; rt_val = b;
    @(negedge clk);
    m = model(ins, pc, a, b);
    check(tag, "next_pc", next_pc, m[31:0]);
    check(tag, "taken", {31'd0, taken}, {31'd0, m[32]});
    check("R8", "less_than", {31'd0, less_than}, {31'd0, $signed(a) < $signed(b)});
    if (pcq_known) check("R10", "pc_q", pc_q, exp_pcq);
  endtask

  function automatic logic [31:0] ifmt(input int op, input int rs, input int rt, input int off);
    return {6'(op), 5'(rs), 5'(rt), 16'(off)};
  endfunction

  initial begin
    #5000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9", "pc_q reset", pc_q, RV);
    #1 rst = 1'b0;

    apply("R7", {6'd0, 5'd19, 5'd19, 5'd9, 5'd0, 6'd32}, 32'd80000, 32'd3, 32'd3);
    apply("R1", ifmt(35, 9, 8, 0), 32'd80012, 32'd5, 32'd7);
    apply("R2", ifmt(4, 8, 21, 2), 32'd80016, 32'd42, 32'd42);
    apply("R2", ifmt(4, 8, 21, 2), 32'd80016, 32'd42, 32'd43);
    apply("R3", ifmt(5, 8, 21, 2), 32'd80016, 32'd1, 32'd9);
    apply("R3", ifmt(5, 8, 21, 2), 32'd80016, 32'd9, 32'd9);
    apply("R4", ifmt(5, 8, 21, 16'hFFFD), 32'd80016, 32'd0, 32'd1);
    apply("R4", ifmt(4, 1, 2, 16'h8000), 32'h0000_0010, 32'd6, 32'd6);
    apply("R4", ifmt(4, 1, 2, 16'h7FFF), 32'hFFFF_FFF0, 32'd6, 32'd6);
    apply("R5", {6'd2, 26'd20000}, 32'd80024, 32'd0, 32'd0);
    apply("R5", {6'd2, 26'h3FF_FFFF}, 32'hA123_4568, 32'd0, 32'd0);
    apply("R6", {6'd0, 5'd8, 15'd0, 6'd8}, 32'd400, 32'hDEAD_BEE0, 32'd0);
    apply("R7", {6'd0, 5'd8, 15'd0, 6'd9}, 32'd400, 32'hDEAD_BEE0, 32'd0);
    apply("R1", ifmt(3, 0, 0, 5), 32'd800, 32'd0, 32'd0);
    apply("R8", ifmt(8, 0, 0, 0), 32'd0, 32'hFFFF_FFFF, 32'd1);
    apply("R8", ifmt(8, 0, 0, 0), 32'd0, 32'h7FFF_FFFF, 32'h8000_0000);

    lf = 32'hACE1_1234;
    for (int i = 0; i < 200; i++) begin
      logic [31:0] ins;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      ins = {lf[3] ? 6'(lf[2:0] & 3'd5) : lf[31:26], lf[25:6], lf[1] ? 6'd8 : lf[5:0]};
      apply("R10", ins, pc_q, lf ^ 32'h1357_9BDF, lf[0] ? (lf ^ 32'h1357_9BDF) : {lf[15:0], lf[31:16]});
    end

    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R9", "pc_q rereset", pc_q, RV);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule